// File: doc/BRIEF.md
# External-Memory Ring Buffer Manager

This block runs a byte-stream circular FIFO whose storage is a window of external memory, given by a base address and a size in bytes. A producer asks for a write of any length and a consumer asks for a read of any length. The block breaks each request into bursts and issues them one at a time on a plain memory request port. Each burst carries an address, a length, a write/read flag and the offset of the burst inside its request. The memory side answers each burst with a one-cycle done pulse. The memory model uses the offset to find the producer's source bytes or the consumer's destination bytes.

The block keeps the write position, the read position and the fill level of the ring. A request that does not fit stalls; it does not fail. A write stalls when the free space is too small, and a read stalls when there is too little data. Each stall adds one to that side's counter. The request is tried again after the other side completes a burst. Fill, free space, window size and both stall counters are always visible on output ports.

Top module: `ext_ring_mgr`

## Requirements
- R1: Every burst length equals the smallest of three values: the bytes still owed to its request, MAX_BURST, and the window size minus the current position of that side. It is never zero.
- R2: A burst's address is the window base plus that side's position, modulo 2^AW. Its offset field equals the number of bytes of the same request already moved.
- R3: When a write burst completes, fill and the write position each grow by the burst length. The write position returns to 0 when it reaches the window size.
- R4: When a read burst completes, fill shrinks and the read position grows by the burst length, with the same return to 0. Bytes are read back in the order they were written.
- R5: A write whose next burst is longer than the free space stalls, and the overflow count grows by exactly one for that stall, however long it lasts. The check is repeated after each completed read burst, and each repeat that still finds too little space counts again.
- R6: A read whose next burst is longer than fill stalls and adds one to the underrun count. The check is repeated after each completed write burst, with the same counting rule as R5.
- R7: free_level always equals total_size minus fill_level, and fill_level never exceeds total_size.
- R8: At most one burst is outstanding. mem_req_write is 1 for a write burst and 0 for a read burst. All request fields hold steady from the cycle mem_req_valid rises until the cycle mem_done is seen.
- R9: When both sides are ready to issue in the same cycle, the grant goes to the side that did not receive the previous grant.
- R10: Reset clears both positions, fill, both counters and the request port.
- R11: cfg_base and cfg_size are taken only while no request is active and no burst is outstanding. Changes made during activity have no effect. When a change is taken, the ring is emptied and both positions restart at 0.
- R12: A start with length 0 is ignored. A start on a side that is already busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Window base address |
| cfg_size | input | LW | Window size in bytes |
| wr_start | input | 1 | Pulse: begin a producer request |
| wr_len | input | RW | Producer request length in bytes |
| wr_busy | output | 1 | Producer request in progress |
| rd_start | input | 1 | Pulse: begin a consumer request |
| rd_len | input | RW | Consumer request length in bytes |
| rd_busy | output | 1 | Consumer request in progress |
| mem_req_valid | output | 1 | A burst is outstanding |
| mem_req_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | AW | Burst start address |
| mem_req_len | output | $clog2(MAX_BURST+1) | Burst length in bytes |
| mem_req_off | output | RW | Burst offset within its request |
| mem_done | input | 1 | One-cycle completion of the outstanding burst |
| fill_level | output | LW | Bytes held in the ring |
| free_level | output | LW | Bytes of free space |
| total_size | output | LW | Window size in use |
| overflow_cnt | output | CW | Count of write stall episodes |
| underrun_cnt | output | CW | Count of read stall episodes |

## Verification
The bench sweeps every request length up to the window size. It uses two window sizes, one of them placed so that addresses wrap past the top of memory. Every burst is compared with an arithmetic model of length, address and offset. A design that ignored the window end would issue a burst running past the window, and one that dropped the wrap would return bytes out of order. Directed stall cases hold a full ring and an empty ring for many cycles. A counter that counted per cycle would overshoot, and one that skipped the recheck after a partial drain would miss the second count. Further cases cover simultaneous requests, which catch a fixed-priority arbiter by two back-to-back grants to one side, and a window change both during activity and while idle.

// File: rtl/ext_ring_pkg.sv
package ext_ring_pkg;
   // smallest of three unsigned values, used for burst sizing
   function automatic int unsigned min3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a < b) ? a : b;
      return (m < c) ? m : c;
   endfunction
endpackage

// File: rtl/ext_ring_side.sv
module ext_ring_side #(
   parameter int LW   = 16,
   parameter int RW   = 16,
   parameter int MAXB = 64,
   parameter int BW   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] start_len,
   input  logic [LW-1:0] size,
   input  logic [LW-1:0] room,
   input  logic          grant,
   input  logic          done,
   input  logic          other_done,
   input  logic          clr,
   output logic          busy,
   output logic [LW-1:0] pos,
   output logic [RW-1:0] off,
   output logic [BW-1:0] blen,
   output logic          want,
   output logic          stall_evt
);
   localparam int LW1 = LW + 1;

   logic [RW-1:0] rem_q;
   logic          stalled_q, inflight_q, can_try, fits;
   logic [LW:0]   nxt_pos;

   always_comb begin
      blen      = BW'(ext_ring_pkg::min3(32'(rem_q), 32'(MAXB), 32'(size - pos)));
      can_try   = busy && !stalled_q && !inflight_q && (size != '0);
      fits      = 32'(room) >= 32'(blen);
      want      = can_try && fits && (blen != '0);
      stall_evt = can_try && !fits && !other_done;
      nxt_pos   = LW1'(pos) + LW1'(blen);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         rem_q      <= '0;
         off        <= '0;
         pos        <= '0;
         stalled_q  <= 1'b0;
         inflight_q <= 1'b0;
      end else begin
         if (clr) pos <= '0;
         if (!busy && start && (start_len != '0)) begin
            busy  <= 1'b1;
            rem_q <= start_len;
            off   <= '0;
         end
         if (grant) inflight_q <= 1'b1;
         if (done) begin
            inflight_q <= 1'b0;
            rem_q      <= rem_q - RW'(blen);
            off        <= off + RW'(blen);
            pos        <= (nxt_pos >= LW1'(size)) ? '0 : nxt_pos[LW-1:0];
            if (rem_q == RW'(blen)) busy <= 1'b0;
         end
         if (other_done)     stalled_q <= 1'b0;
         else if (stall_evt) stalled_q <= 1'b1;
      end
   end

   // a granted burst never runs past the end of the window
   assert_burst_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      want |-> (32'(pos) + 32'(blen) <= 32'(size)));
   // one count per blocking episode (R5 on the write side, R6 on the read side)
   assert_one_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stall_evt |=> !stall_evt);
   // completion only arrives for a burst this side owns
   assert_done_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> inflight_q);
endmodule

// File: rtl/ext_ring_arb.sv
module ext_ring_arb #(
   parameter int AW = 24,
   parameter int LW = 16,
   parameter int RW = 16,
   parameter int BW = 7,
   parameter int MAXB = 64,
   parameter bit RR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want_w,
   input  logic          want_r,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] pos_w,
   input  logic [LW-1:0] pos_r,
   input  logic [RW-1:0] off_w,
   input  logic [RW-1:0] off_r,
   input  logic [BW-1:0] blen_w,
   input  logic [BW-1:0] blen_r,
   input  logic          mem_done,
   output logic          grant_w,
   output logic          grant_r,
   output logic          done_w,
   output logic          done_r,
   output logic          req_valid,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   output logic [BW-1:0] req_len,
   output logic [RW-1:0] req_off
);
   logic pick_r;

   generate
      if (RR) begin : g_rr
         logic last_w_q;
         always_comb pick_r = want_r && (!want_w || last_w_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       last_w_q <= 1'b0;
            else if (grant_w) last_w_q <= 1'b1;
            else if (grant_r) last_w_q <= 1'b0;
         end
      end else begin : g_wfirst
         always_comb pick_r = want_r && !want_w;
      end
   endgenerate

   always_comb begin
      grant_r = !req_valid && pick_r;
      grant_w = !req_valid && want_w && !pick_r;
      done_w  = req_valid && mem_done && req_write;
      done_r  = req_valid && mem_done && !req_write;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_len   <= '0;
         req_off   <= '0;
      end else if (grant_w || grant_r) begin
         req_valid <= 1'b1;
         req_write <= grant_w;
         req_addr  <= base + AW'(grant_w ? pos_w : pos_r);
         req_len   <= grant_w ? blen_w : blen_r;
         req_off   <= grant_w ? off_w : off_r;
      end else if (req_valid && mem_done) begin
         req_valid <= 1'b0;
      end
   end

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_done) |=> (req_valid && $stable(req_addr) && $stable(req_len)
                                    && $stable(req_write) && $stable(req_off)));
   assert_len_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0) && (32'(req_len) <= 32'(MAXB)));
endmodule

// File: rtl/ext_ring_mgr.sv
module ext_ring_mgr #(
   parameter int AW   = 24,
   parameter int LW   = 16,
   parameter int RW   = 16,
   parameter int MAXB = 64,
   parameter int CW   = 16,
   parameter bit RR   = 1'b1,
   localparam int BW  = $clog2(MAXB + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_base,
   input  logic [LW-1:0] cfg_size,
   input  logic          wr_start,
   input  logic [RW-1:0] wr_len,
   output logic          wr_busy,
   input  logic          rd_start,
   input  logic [RW-1:0] rd_len,
   output logic          rd_busy,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [AW-1:0] mem_req_addr,
   output logic [BW-1:0] mem_req_len,
   output logic [RW-1:0] mem_req_off,
   input  logic          mem_done,
   output logic [LW-1:0] fill_level,
   output logic [LW-1:0] free_level,
   output logic [LW-1:0] total_size,
   output logic [CW-1:0] overflow_cnt,
   output logic [CW-1:0] underrun_cnt
);
   generate
      if (MAXB < 1)  begin : g_bad_burst $error("MAXB must be at least 1"); end
      if (AW < LW)   begin : g_bad_aw    $error("AW must cover the window size width"); end
      if (LW > 31 || RW > 31) begin : g_bad_w $error("LW and RW must stay below 32"); end
   endgenerate

   logic [AW-1:0] base_q;
   logic [LW-1:0] size_q, fill_q, room_w;
   logic [CW-1:0] ovf_q, udr_q;
   logic          idle, reconf;
   logic          busy_w, busy_r, want_w, want_r, stall_w, stall_r;
   logic          grant_w, grant_r, done_w, done_r;
   logic [LW-1:0] pos_w, pos_r;
   logic [RW-1:0] off_w, off_r;
   logic [BW-1:0] blen_w, blen_r;

   always_comb begin
      idle   = !busy_w && !busy_r && !mem_req_valid;
      reconf = idle && ((cfg_base != base_q) || (cfg_size != size_q));
      room_w = size_q - fill_q;
   end

   ext_ring_side #(.LW(LW), .RW(RW), .MAXB(MAXB), .BW(BW)) u_wr (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .start_len(wr_len), .size(size_q),
      .room(room_w), .grant(grant_w), .done(done_w), .other_done(done_r), .clr(reconf),
      .busy(busy_w), .pos(pos_w), .off(off_w), .blen(blen_w), .want(want_w),
      .stall_evt(stall_w));

   ext_ring_side #(.LW(LW), .RW(RW), .MAXB(MAXB), .BW(BW)) u_rd (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .start_len(rd_len), .size(size_q),
      .room(fill_q), .grant(grant_r), .done(done_r), .other_done(done_w), .clr(reconf),
      .busy(busy_r), .pos(pos_r), .off(off_r), .blen(blen_r), .want(want_r),
      .stall_evt(stall_r));

   ext_ring_arb #(.AW(AW), .LW(LW), .RW(RW), .BW(BW), .MAXB(MAXB), .RR(RR)) u_arb (
      .clk(clk), .rst_n(rst_n), .want_w(want_w), .want_r(want_r), .base(base_q),
      .pos_w(pos_w), .pos_r(pos_r), .off_w(off_w), .off_r(off_r),
      .blen_w(blen_w), .blen_r(blen_r), .mem_done(mem_done),
      .grant_w(grant_w), .grant_r(grant_r), .done_w(done_w), .done_r(done_r),
      .req_valid(mem_req_valid), .req_write(mem_req_write), .req_addr(mem_req_addr),
      .req_len(mem_req_len), .req_off(mem_req_off));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         fill_q <= '0;
         ovf_q  <= '0;
         udr_q  <= '0;
      end else begin
         if (idle) begin
            base_q <= cfg_base;
            size_q <= cfg_size;
         end
         if (reconf)      fill_q <= '0;
         else if (done_w) fill_q <= fill_q + LW'(blen_w);
         else if (done_r) fill_q <= fill_q - LW'(blen_r);
         if (stall_w) ovf_q <= ovf_q + 1'b1;
         if (stall_r) udr_q <= udr_q + 1'b1;
      end
   end

   assign wr_busy      = busy_w;
   assign rd_busy      = busy_r;
   assign fill_level   = fill_q;
   assign free_level   = size_q - fill_q;
   assign total_size   = size_q;
   assign overflow_cnt = ovf_q;
   assign underrun_cnt = udr_q;

   assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= size_q);
   assert_reconf_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |=> (fill_level == '0));
   assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_w, done_r}));
endmodule

// File: tb/ext_ring_mgr_tb.sv
module ext_ring_mgr_tb_top;
   localparam int AW = 10, LW = 6, RW = 8, MAXB = 8, CW = 8;
   localparam int BW = $clog2(MAXB + 1);
   localparam int MSZ = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [LW-1:0] cfg_size = '0;
   logic wr_start = 0, rd_start = 0, mem_done = 0;
   logic [RW-1:0] wr_len = '0, rd_len = '0;
   logic wr_busy, rd_busy, mem_req_valid, mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [BW-1:0] mem_req_len;
   logic [RW-1:0] mem_req_off;
   logic [LW-1:0] fill_level, free_level, total_size;
   logic [CW-1:0] overflow_cnt, underrun_cnt;

   always #4 clk = ~clk;

   ext_ring_mgr #(.AW(AW), .LW(LW), .RW(RW), .MAXB(MAXB), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .wr_start(wr_start), .wr_len(wr_len), .wr_busy(wr_busy),
      .rd_start(rd_start), .rd_len(rd_len), .rd_busy(rd_busy),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_req_off(mem_req_off),
      .mem_done(mem_done), .fill_level(fill_level), .free_level(free_level),
      .total_size(total_size), .overflow_cnt(overflow_cnt), .underrun_cnt(underrun_cnt));

   int n_tests = 0, n_fail = 0;
   logic [7:0] mem [0:MSZ-1];
   int m_base = 0, m_size = 0, m_wpos = 0, m_rpos = 0, m_fill = 0;
   int m_wrem = 0, m_rrem = 0, m_woff = 0, m_roff = 0;
   int m_wsb = 0, m_rsb = 0, m_wtot = 0, m_rtot = 0;
   bit rr_on = 0;
   int rr_prev = -1, rr_viol = 0, rr_cnt = 0, bursts = 0;

   function automatic int min3(int a, int b, int c);
      int m;
      m = (a < b) ? a : b;
      return (m < c) ? m : c;
   endfunction

   function automatic logic [7:0] pat(int n);
      return 8'((n * 37 + 11) ^ (n >> 3));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // memory responder with a reference model of positions and fill
   initial begin
      for (int i = 0; i < MSZ; i++) mem[i] = 8'h00;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req_valid) begin
            int a, ln, of, el, lat;
            bit w, dok;
            a = int'(mem_req_addr); ln = int'(mem_req_len); of = int'(mem_req_off);
            w = mem_req_write;
            bursts++;
            if (w) begin
               el = min3(m_wrem, MAXB, m_size - m_wpos);
               chk(m_wrem > 0, "R8 unexpected write burst", m_wrem, 1);
               chk(ln == el, "R1 write burst length", ln, el);
               chk(a == (m_base + m_wpos) % MSZ, "R2 write address", a, (m_base + m_wpos) % MSZ);
               chk(of == m_woff, "R2 write offset", of, m_woff);
            end else begin
               el = min3(m_rrem, MAXB, m_size - m_rpos);
               chk(m_rrem > 0, "R8 unexpected read burst", m_rrem, 1);
               chk(ln == el, "R1 read burst length", ln, el);
               chk(a == (m_base + m_rpos) % MSZ, "R2 read address", a, (m_base + m_rpos) % MSZ);
               chk(of == m_roff, "R2 read offset", of, m_roff);
            end
            if (rr_on) begin
               if (rr_prev == int'(w) && (w ? (m_rrem > 0) : (m_wrem > 0))) rr_viol++;
               rr_prev = int'(w);
               rr_cnt++;
            end
            lat = 1 + bursts % 3;
            repeat (lat) begin
               @(negedge clk);
               chk(mem_req_valid && int'(mem_req_addr) == a && int'(mem_req_len) == ln
                   && mem_req_write == w && int'(mem_req_off) == of,
                   "R8 request held", int'(mem_req_addr), a);
            end
            if (w) begin
               for (int i = 0; i < ln; i++) mem[(a + i) % MSZ] = pat(m_wsb + of + i);
               m_wpos = (m_wpos + ln >= m_size) ? 0 : m_wpos + ln;
               m_fill += ln; m_wrem -= ln; m_woff += ln; m_wtot += ln;
            end else begin
               dok = 1;
               for (int i = 0; i < ln; i++)
                  if (mem[(a + i) % MSZ] != pat(m_rsb + of + i)) dok = 0;
               chk(dok, "R4 read data order", int'(mem[a % MSZ]), int'(pat(m_rsb + of)));
               m_rpos = (m_rpos + ln >= m_size) ? 0 : m_rpos + ln;
               m_fill -= ln; m_rrem -= ln; m_roff += ln; m_rtot += ln;
            end
            mem_done = 1'b1;
            @(negedge clk);
            mem_done = 1'b0;
         end
      end
   end

   task automatic start_req(input bit dow, input int wl, input bit dor, input int rl);
      @(negedge clk);
      if (dow) begin
         wr_start = 1'b1; wr_len = RW'(wl);
         if (!wr_busy && wl != 0) begin m_wrem = wl; m_woff = 0; m_wsb = m_wtot; end
      end
      if (dor) begin
         rd_start = 1'b1; rd_len = RW'(rl);
         if (!rd_busy && rl != 0) begin m_rrem = rl; m_roff = 0; m_rsb = m_rtot; end
      end
      @(negedge clk);
      wr_start = 1'b0; rd_start = 1'b0;
   endtask

   task automatic wait_idle();
      int t;
      t = 0;
      while ((wr_busy || rd_busy || mem_req_valid) && t < 5000) begin
         @(negedge clk); t++;
      end
      chk(t < 5000, "R8 request never finished", t, 0);
   endtask

   task automatic check_levels(input string tag);
      chk(int'(fill_level) == m_fill, {tag, " fill"}, int'(fill_level), m_fill);
      chk(int'(free_level) == m_size - m_fill, "R7 free level", int'(free_level), m_size - m_fill);
      chk(int'(total_size) == m_size, "R7 total size", int'(total_size), m_size);
   endtask

   task automatic set_cfg(input int b, input int s);
      wait_idle();
      @(negedge clk);
      cfg_base = AW'(b); cfg_size = LW'(s);
      m_base = b; m_size = s; m_wpos = 0; m_rpos = 0; m_fill = 0; m_rtot = m_wtot;
      @(negedge clk); @(negedge clk);
      chk(fill_level == '0, "R11 reconfig empties ring", int'(fill_level), 0);
      chk(int'(total_size) == s, "R11 new size taken", int'(total_size), s);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int o0, u0;
      cfg_base = AW'(100); cfg_size = LW'(13);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(fill_level == '0 && overflow_cnt == '0 && underrun_cnt == '0, "R10 reset counters", int'(fill_level), 0);
      chk(!mem_req_valid && !wr_busy && !rd_busy, "R10 reset idle port", int'(mem_req_valid), 0);
      @(negedge clk);
      m_base = 100; m_size = 13;
      chk(int'(total_size) == 13, "R11 size sampled after reset", int'(total_size), 13);

      // R1 R2 R3 R4 sweep: every length, two windows (second wraps the address space)
      for (int s = 0; s < 2; s++) begin
         if (s == 1) set_cfg(1010, 24);
         for (int l = 1; l <= m_size; l++) begin
            start_req(1, l, 0, 0); wait_idle(); check_levels("R3");
            start_req(0, 0, 1, l); wait_idle(); check_levels("R4");
         end
      end

      // R12 zero length is ignored
      start_req(1, 0, 1, 0);
      repeat (5) @(negedge clk);
      chk(!wr_busy && !rd_busy && !mem_req_valid, "R12 zero length ignored", int'(wr_busy), 0);
      check_levels("R12");

      // R5 overflow: full ring, one count per episode, recount after a partial drain
      set_cfg(200, 16);
      o0 = int'(overflow_cnt);
      start_req(1, 16, 0, 0); wait_idle();
      start_req(1, 4, 0, 0);
      repeat (6) @(negedge clk);
      chk(int'(overflow_cnt) == o0 + 1, "R5 first overflow count", int'(overflow_cnt), o0 + 1);
      repeat (20) @(negedge clk);
      chk(int'(overflow_cnt) == o0 + 1, "R5 count once per episode", int'(overflow_cnt), o0 + 1);
      chk(wr_busy && !mem_req_valid, "R5 writer stalled", int'(mem_req_valid), 0);
      start_req(1, 5, 0, 0); // R12 ignored while busy
      start_req(0, 0, 1, 2);
      while (rd_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(int'(overflow_cnt) == o0 + 2, "R5 recheck after read still short", int'(overflow_cnt), o0 + 2);
      chk(wr_busy, "R5 writer still waiting", int'(wr_busy), 1);
      start_req(0, 0, 1, 2); wait_idle();
      chk(int'(overflow_cnt) == o0 + 2, "R5 no further count", int'(overflow_cnt), o0 + 2);
      check_levels("R12 busy start ignored");
      start_req(0, 0, 1, 16); wait_idle(); check_levels("R4");

      // R6 underrun, and R11 config change while busy has no effect
      u0 = int'(underrun_cnt);
      start_req(0, 0, 1, 3);
      repeat (6) @(negedge clk);
      chk(int'(underrun_cnt) == u0 + 1, "R6 underrun count", int'(underrun_cnt), u0 + 1);
      cfg_size = LW'(5); cfg_base = AW'(7);
      repeat (4) @(negedge clk);
      chk(int'(total_size) == 16, "R11 size ignored while busy", int'(total_size), 16);
      cfg_size = LW'(16); cfg_base = AW'(200);
      repeat (10) @(negedge clk);
      chk(int'(underrun_cnt) == u0 + 1, "R6 count once per episode", int'(underrun_cnt), u0 + 1);
      start_req(1, 3, 0, 0); wait_idle();
      chk(int'(underrun_cnt) == u0 + 1, "R6 reader resumed without recount", int'(underrun_cnt), u0 + 1);
      check_levels("R6");

      // R11 reconfig with data present empties ring; next burst at new base
      start_req(1, 5, 0, 0); wait_idle(); check_levels("R3");
      set_cfg(300, 20);
      start_req(1, 4, 0, 0); wait_idle();
      start_req(0, 0, 1, 4); wait_idle(); check_levels("R11");

      // R9 round robin with both sides ready
      start_req(1, 10, 0, 0); wait_idle();
      rr_on = 1; rr_prev = -1; rr_viol = 0; rr_cnt = 0;
      start_req(1, 10, 1, 10); wait_idle();
      rr_on = 0;
      chk(rr_viol == 0, "R9 grants alternate", rr_viol, 0);
      chk(rr_cnt >= 4, "R9 bursts observed", rr_cnt, 4);
      check_levels("R9");

      // concurrent sweep, bytes still checked in order
      set_cfg(50, 24);
      start_req(1, 12, 0, 0); wait_idle();
      for (int l = 1; l <= 12; l++) begin
         start_req(1, l, 1, l); wait_idle(); check_levels("R3 concurrent");
      end
      start_req(0, 0, 1, 12); wait_idle(); check_levels("R4");

      finish_run();
   end
endmodule